// File: doc/BRIEF.md
# Masked SIMD Processing Element Array

This block is a row of identical processing elements under one control unit. Each cycle the control unit takes at most one instruction from a valid/ready input. Scalar instructions (a no-op and a repeat-count load) are handled inside the control unit. All other instructions go to every element at once. Each element holds a 16-bit accumulator and a 16-bit operand register. Array instructions are local ALU operations, operand routing between elements, or updates to the enable mask.

Every element has one bit in an enable mask. An element that is disabled keeps its registers unchanged. During routing it still supplies its accumulator to its neighbours, so a ring shift passes through disabled elements intact. A repeat instruction makes the next array instruction run several times in a row, and the input is stalled while this happens. A separate port can overwrite the mask directly. The registers of all elements and the mask can be read at all times. A done pulse marks the completion of each array instruction.

Top module: `simd_array_top`

## Requirements
- R1: After reset, every accumulator and operand register is zero, every mask bit is 1 (enabled), `in_ready` is 1 and `done_o` is 0.
- R2: The instruction word is `{opcode[20:16], imm[15:0]}`. The immediate is sign-extended to the register width. In an enabled element the local opcodes do the following:
  - 0x08: acc = imm
  - 0x09: acc = acc + imm
  - 0x0A: acc = acc + opr
  - 0x0B: acc = acc − opr
  - 0x0C: acc = acc & opr
  - 0x0D: acc = acc | opr
  - 0x0E: acc = acc ^ opr
  - 0x0F: opr = acc
- R3: An element whose mask bit is 0 leaves both of its registers unchanged under any local or routing instruction.
- R4: Ring shift left (0x10) loads the operand of each enabled element i with the accumulator of element (i+1) mod N. Ring shift right (0x11) loads it with the accumulator of element (i−1) mod N. Disabled elements still provide their accumulator as a source.
- R5: Broadcast (0x12) loads the operand of every enabled element with the accumulator of element 0.
- R6: Mask load (0x18) sets mask bit i to imm bit i for all elements, whatever the current mask.
- R7: Mask compare sets every mask bit from its element's accumulator, whatever the current mask. Opcode 0x19 sets the bit when the accumulator is zero. Opcode 0x1A sets it from the accumulator's sign bit.
- R8: Repeat (0x01) with count c makes the next array instruction execute max(c,1) times on consecutive cycles. `in_ready` is 0 during the c−1 re-issue cycles, and the count is then consumed.
- R9: Each array instruction, including unassigned codes 0x13–0x17 and 0x1B–0x1F (which change nothing), produces exactly one `done_o` pulse. The pulse comes in the cycle after its final execution, and the new register values are visible in that same cycle.
- R10: Scalar instructions (codes 0x00–0x07) change no element register or mask bit and produce no `done_o`.
- R11: When `mask_ld` is 1, the mask takes `mask_ld_val` at the next edge. This has priority over any mask instruction issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction valid |
| in_ready | output | 1 | Instruction can be accepted |
| in_instr | input | 21 | Opcode [20:16], immediate [15:0] |
| mask_ld | input | 1 | Direct mask write strobe |
| mask_ld_val | input | N_PE | Mask value for direct write, bit i for element i |
| acc_o | output | N_PE*DW | Accumulators, element i at [i*DW +: DW] |
| opr_o | output | N_PE*DW | Operand registers, element i at [i*DW +: DW] |
| mask_o | output | N_PE | Current enable mask |
| done_o | output | 1 | Array instruction completed |

## Verification
The assertions check the following on every cycle:
- A disabled or idle element holds its registers.
- The repeat counter steps down by one until it reaches its final pass, which raises done.
- A direct mask write or a mask-load instruction lands at the next edge.
- A ring shift left delivers element 1's accumulator to element 0.

Only the scenarios show the arithmetic results across all elements under mixed masks and routing that passes through disabled neighbours. They also show the sign and zero compares, the exact stall length and the pulse count of each repeat, and that scalar and unassigned codes leave the state untouched.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int OPW   = 5;
    localparam int IMM_W = 16;
    localparam int IW    = OPW + IMM_W;

    typedef enum logic [OPW-1:0] {
        OP_NOP   = 5'h00,
        OP_RPT   = 5'h01,
        OP_LDI   = 5'h08,
        OP_ADDI  = 5'h09,
        OP_ADD   = 5'h0A,
        OP_SUB   = 5'h0B,
        OP_AND   = 5'h0C,
        OP_OR    = 5'h0D,
        OP_XOR   = 5'h0E,
        OP_MOVO  = 5'h0F,
        OP_SHL   = 5'h10,
        OP_SHR   = 5'h11,
        OP_BCAST = 5'h12,
        OP_MLDI  = 5'h18,
        OP_MZERO = 5'h19,
        OP_MNEG  = 5'h1A
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [IMM_W-1:0] imm;
    } instr_t;

    // Class is given by the two top opcode bits: 00 scalar, 01 local, 10 route, 11 mask
    function automatic logic [1:0] op_class(op_e o);
        logic [OPW-1:0] v;
        v = o;
        return v[OPW-1:OPW-2];
    endfunction

    function automatic logic is_array(op_e o);
        return op_class(o) != 2'b00;
    endfunction

    function automatic logic is_mask(op_e o);
        return op_class(o) == 2'b11;
    endfunction

endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
    import simd_pkg::*;
#(
    parameter int CNTW = IMM_W
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    output logic   in_ready,
    input  instr_t in_instr,
    output logic   iss_valid,
    output instr_t iss_instr,
    output logic   done
);

    logic            busy;
    logic [CNTW-1:0] pend;
    logic [CNTW-1:0] remain;
    instr_t          held;
    logic            accept;
    logic            arr_in;

    assign in_ready  = !busy;
    assign accept    = in_valid && !busy;
    assign arr_in    = is_array(in_instr.op);
    assign iss_valid = busy || (accept && arr_in);
    assign iss_instr = busy ? held : in_instr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            pend   <= '0;
            remain <= '0;
            held   <= '{op: OP_NOP, imm: '0};
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                remain <= remain - 1'b1;
                if (remain == CNTW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else if (accept) begin
                if (arr_in) begin
                    held <= in_instr;
                    pend <= '0;
                    if (pend > CNTW'(1)) begin
                        busy   <= 1'b1;
                        remain <= pend - 1'b1;
                    end else begin
                        done <= 1'b1;
                    end
                end else if (in_instr.op == OP_RPT) begin
                    pend <= in_instr.imm[CNTW-1:0];
                end
            end
        end
    end

    // R8: the re-issue counter steps down by one per cycle while more passes remain
    a_r8_countdown: assert property (@(posedge clk) disable iff (rst)
        (busy && remain > CNTW'(1)) |=> (busy && remain == $past(remain) - 1'b1));

    // R9: the last re-issue pass ends the stall and raises done
    a_r9_done_last: assert property (@(posedge clk) disable iff (rst)
        (busy && remain == CNTW'(1)) |=> (done && !busy));

    // R9: a single-pass array instruction completes with done next cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        (accept && arr_in && pend <= CNTW'(1)) |=> done);

endmodule

// File: rtl/simd_route.sv
module simd_route
    import simd_pkg::*;
#(
    parameter int N_PE = 8,
    parameter int DW   = 16
) (
    input  op_e                      op,
    input  logic [N_PE-1:0][DW-1:0]  acc,
    output logic [N_PE-1:0][DW-1:0]  nbr
);

    for (genvar i = 0; i < N_PE; i++) begin : g_lane
        localparam int LEFT_SRC  = (i + 1) % N_PE;
        localparam int RIGHT_SRC = (i + N_PE - 1) % N_PE;
        always_comb begin
            case (op)
                OP_SHL:  nbr[i] = acc[LEFT_SRC];
                OP_SHR:  nbr[i] = acc[RIGHT_SRC];
                OP_BCAST: nbr[i] = acc[0];
                default: nbr[i] = acc[i];
            endcase
        end
    end

endmodule

// File: rtl/simd_pe.sv
module simd_pe
    import simd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          issue,
    input  instr_t        instr,
    input  logic [DW-1:0] nbr,
    output logic [DW-1:0] acc_o,
    output logic [DW-1:0] opr_o
);

    logic [DW-1:0] acc_q, opr_q, acc_n, opr_n, imm_x;

    if (DW > IMM_W) begin : g_sext
        assign imm_x = {{(DW-IMM_W){instr.imm[IMM_W-1]}}, instr.imm};
    end else begin : g_trunc
        assign imm_x = instr.imm[DW-1:0];
    end

    always_comb begin
        acc_n = acc_q;
        opr_n = opr_q;
        case (instr.op)
            OP_LDI:   acc_n = imm_x;
            OP_ADDI:  acc_n = acc_q + imm_x;
            OP_ADD:   acc_n = acc_q + opr_q;
            OP_SUB:   acc_n = acc_q - opr_q;
            OP_AND:   acc_n = acc_q & opr_q;
            OP_OR:    acc_n = acc_q | opr_q;
            OP_XOR:   acc_n = acc_q ^ opr_q;
            OP_MOVO:  opr_n = acc_q;
            OP_SHL, OP_SHR, OP_BCAST: opr_n = nbr;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            opr_q <= '0;
        end else if (issue && en) begin
            acc_q <= acc_n;
            opr_q <= opr_n;
        end
    end

    assign acc_o = acc_q;
    assign opr_o = opr_q;

    // R3: a masked-off element holds both registers
    a_r3_disabled_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(acc_q) && $stable(opr_q)));

    // R10: without an issued array instruction the element state does not move
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !issue |=> ($stable(acc_q) && $stable(opr_q)));

endmodule

// File: rtl/simd_array_top.sv
module simd_array_top
    import simd_pkg::*;
#(
    parameter int N_PE = 8,
    parameter int DW   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [IW-1:0]      in_instr,
    input  logic               mask_ld,
    input  logic [N_PE-1:0]    mask_ld_val,
    output logic [N_PE*DW-1:0] acc_o,
    output logic [N_PE*DW-1:0] opr_o,
    output logic [N_PE-1:0]    mask_o,
    output logic               done_o
);

    instr_t                  in_s, iss_instr;
    logic                    iss_valid;
    logic [N_PE-1:0][DW-1:0] acc_a, opr_a, nbr_a;
    logic [N_PE-1:0]         mask_q, zero_v, neg_v, mldi_v;

    assign in_s = instr_t'(in_instr);

    simd_ctrl #(.CNTW(IMM_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_instr  (in_s),
        .iss_valid (iss_valid),
        .iss_instr (iss_instr),
        .done      (done_o)
    );

    simd_route #(.N_PE(N_PE), .DW(DW)) u_route (
        .op  (iss_instr.op),
        .acc (acc_a),
        .nbr (nbr_a)
    );

    for (genvar i = 0; i < N_PE; i++) begin : g_pe
        simd_pe #(.DW(DW)) u_pe (
            .clk   (clk),
            .rst   (rst),
            .en    (mask_q[i]),
            .issue (iss_valid),
            .instr (iss_instr),
            .nbr   (nbr_a[i]),
            .acc_o (acc_a[i]),
            .opr_o (opr_a[i])
        );
        assign zero_v[i] = (acc_a[i] == '0);
        assign neg_v[i]  = acc_a[i][DW-1];
        if (i < IMM_W) begin : g_imm_bit
            assign mldi_v[i] = iss_instr.imm[i];
        end else begin : g_imm_pad
            assign mldi_v[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else if (mask_ld) begin
            mask_q <= mask_ld_val;
        end else if (iss_valid && is_mask(iss_instr.op)) begin
            case (iss_instr.op)
                OP_MLDI:  mask_q <= mldi_v;
                OP_MZERO: mask_q <= zero_v;
                OP_MNEG:  mask_q <= neg_v;
                default: ;
            endcase
        end
    end

    assign acc_o  = acc_a;
    assign opr_o  = opr_a;
    assign mask_o = mask_q;

    // R11: a direct mask write lands at the next edge
    a_r11_port_write: assert property (@(posedge clk) disable iff (rst)
        mask_ld |=> (mask_q == $past(mask_ld_val)));

    // R6: mask-load instruction takes the immediate bits
    a_r6_mask_imm: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_instr.op == OP_MLDI && !mask_ld) |=> (mask_q == $past(mldi_v)));

    // R4: left ring shift delivers element 1's accumulator to an enabled element 0
    a_r4_ring_left: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_instr.op == OP_SHL && mask_q[0]) |=> (opr_a[0] == $past(acc_a[1 % N_PE])));

endmodule

// File: tb/sim_simd_array_top.sv
module sim_simd_array_top;

    localparam int N  = 8;
    localparam int DW = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [20:0]     in_instr = '0;
    logic            mask_ld = 1'b0;
    logic [N-1:0]    mask_ld_val = '0;
    logic [N*DW-1:0] acc_o, opr_o;
    logic [N-1:0]    mask_o;
    logic            done_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #4 clk = ~clk;

    simd_array_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .mask_ld(mask_ld), .mask_ld_val(mask_ld_val),
        .acc_o(acc_o), .opr_o(opr_o), .mask_o(mask_o), .done_o(done_o)
    );

    // Reference model of the requirements
    logic [DW-1:0] m_acc [N];
    logic [DW-1:0] m_opr [N];
    logic [N-1:0]  m_mask;
    logic [15:0]   m_pend;

    typedef struct {
        logic [N*DW-1:0] acc;
        logic [N*DW-1:0] opr;
        logic [N-1:0]    mask;
        string           tag;
    } exp_t;
    exp_t q[$];

    function automatic logic [N*DW-1:0] flat_acc();
        logic [N*DW-1:0] f;
        for (int i = 0; i < N; i++) f[i*DW +: DW] = m_acc[i];
        return f;
    endfunction

    function automatic logic [N*DW-1:0] flat_opr();
        logic [N*DW-1:0] f;
        for (int i = 0; i < N; i++) f[i*DW +: DW] = m_opr[i];
        return f;
    endfunction

    task automatic model_exec(input logic [4:0] op, input logic [15:0] imm);
        logic [DW-1:0] snap [N];
        for (int i = 0; i < N; i++) snap[i] = m_acc[i];
        case (op)
            5'h18: m_mask = imm[N-1:0];
            5'h19: for (int i = 0; i < N; i++) m_mask[i] = (snap[i] == 0);
            5'h1A: for (int i = 0; i < N; i++) m_mask[i] = snap[i][DW-1];
            default: begin
                for (int i = 0; i < N; i++) begin
                    if (m_mask[i]) begin
                        case (op)
                            5'h08: m_acc[i] = imm;
                            5'h09: m_acc[i] = snap[i] + imm;
                            5'h0A: m_acc[i] = snap[i] + m_opr[i];
                            5'h0B: m_acc[i] = snap[i] - m_opr[i];
                            5'h0C: m_acc[i] = snap[i] & m_opr[i];
                            5'h0D: m_acc[i] = snap[i] | m_opr[i];
                            5'h0E: m_acc[i] = snap[i] ^ m_opr[i];
                            5'h0F: m_opr[i] = snap[i];
                            5'h10: m_opr[i] = snap[(i+1)%N];
                            5'h11: m_opr[i] = snap[(i+N-1)%N];
                            5'h12: m_opr[i] = snap[0];
                            default: ;
                        endcase
                    end
                end
            end
        endcase
    endtask

    // Driver: hands one instruction over, updates the model, queues the expectation
    task automatic send(input logic [4:0] op, input logic [15:0] imm, input string tag);
        exp_t e;
        int reps;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_instr = {op, imm};
        if (op[4:3] != 2'b00) begin
            reps = (m_pend > 1) ? int'(m_pend) : 1;
            m_pend = 0;
            for (int r = 0; r < reps; r++) model_exec(op, imm);
            e.acc = flat_acc(); e.opr = flat_opr(); e.mask = m_mask; e.tag = tag;
            q.push_back(e);
        end else if (op == 5'h01) begin
            m_pend = imm;
        end
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic check(input bit ok, input string tag, input logic [N*DW-1:0] act,
                         input logic [N*DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_mask(input logic [N-1:0] v);
        @(negedge clk);
        mask_ld = 1'b1;
        mask_ld_val = v;
        @(posedge clk);
        #1 mask_ld = 1'b0;
        m_mask = v;
        @(negedge clk);
        check(mask_o == v, "R11 direct mask write", {{(N*DW-N){1'b0}}, mask_o},
              {{(N*DW-N){1'b0}}, v});
    endtask

    task automatic drain();
        for (int k = 0; k < 20 && q.size() != 0; k++) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pops one expectation per done pulse
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (q.size() == 0) begin
                check(1'b0, "R9 unexpected done pulse", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(acc_o == e.acc, {e.tag, " acc"}, acc_o, e.acc);
                check(opr_o == e.opr, {e.tag, " opr"}, opr_o, e.opr);
                check(mask_o == e.mask, {e.tag, " mask"}, {{(N*DW-N){1'b0}}, mask_o},
                      {{(N*DW-N){1'b0}}, e.mask});
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!ended) begin
            ended = 1;
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_acc[i] = 0; m_opr[i] = 0; end
        m_mask = '1;
        m_pend = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(acc_o == '0 && opr_o == '0, "R1 registers cleared", acc_o | opr_o, '0);
        check(mask_o == '1 && in_ready && !done_o, "R1 mask, ready, done",
              {{(N*DW-N-2){1'b0}}, in_ready, done_o, mask_o},
              {{(N*DW-N-2){1'b0}}, 2'b10, {N{1'b1}}});

        send(5'h08, 16'd5, "R2 load immediate all");
        // R3: distinct values via single-element masks
        for (int i = 0; i < N; i++) begin
            load_mask(N'(1) << i);
            send(5'h08, 16'(i*3 + 1), "R3 masked load");
        end
        drain();
        load_mask('1);
        send(5'h0F, 16'h0, "R2 copy acc to opr");
        send(5'h09, 16'hFFFE, "R2 add signed immediate");
        send(5'h0A, 16'h0, "R2 add opr");
        send(5'h0B, 16'h0, "R2 sub opr");
        send(5'h09, 16'h0033, "R2 add immediate");
        send(5'h0C, 16'h0, "R2 and");
        send(5'h0D, 16'h0, "R2 or");
        send(5'h0E, 16'h0, "R2 xor");
        send(5'h08, 16'h0100, "R2 reload");
        send(5'h09, 16'h0000, "R2 add zero");
        drain();
        // distinct accumulators for routing
        for (int i = 0; i < N; i++) begin
            load_mask(N'(1) << i);
            send(5'h08, 16'(16'h1000 + i*16'h11), "R3 seed");
        end
        drain();
        load_mask(8'hAA);
        send(5'h10, 16'h0, "R4 ring left through disabled");
        send(5'h11, 16'h0, "R4 ring right through disabled");
        drain();
        load_mask('1);
        send(5'h10, 16'h0, "R4 ring left all");
        send(5'h11, 16'h0, "R4 ring right all");
        send(5'h12, 16'h0, "R5 broadcast element 0");
        send(5'h18, 16'h005A, "R6 mask load immediate");
        send(5'h0A, 16'h0, "R3 add under mask");
        send(5'h18, 16'h0000, "R6 mask load zero");
        send(5'h08, 16'h7777, "R3 all disabled");
        send(5'h18, 16'h00FF, "R6 mask load from all disabled");
        drain();
        // R7 compares
        load_mask(8'h0F);
        send(5'h08, 16'hFFF0, "R7 seed negative");
        drain();
        load_mask(8'h30);
        send(5'h08, 16'h0000, "R7 seed zero");
        drain();
        load_mask('1);
        send(5'h1A, 16'h0, "R7 mask from sign");
        send(5'h09, 16'h0002, "R7 add under sign mask");
        send(5'h19, 16'h0, "R7 mask from zero");
        send(5'h09, 16'h0005, "R7 add under zero mask");
        drain();
        load_mask('1);
        // R8 repeat with stall length
        send(5'h01, 16'd4, "R8 repeat load");
        send(5'h09, 16'h0001, "R8 repeat four");
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(!in_ready, "R8 ready low during repeat", {{(N*DW-1){1'b0}}, in_ready}, '0);
        end
        @(negedge clk);
        check(in_ready, "R8 ready back high", {{(N*DW-1){1'b0}}, in_ready}, 1);
        send(5'h01, 16'd0, "R8 repeat zero");
        send(5'h09, 16'h0010, "R8 zero count runs once");
        send(5'h01, 16'd3, "R8 repeat three");
        send(5'h10, 16'h0, "R8 repeated ring left");
        send(5'h09, 16'h0001, "R8 count consumed");
        drain();
        // R10 scalar codes leave state alone and give no done
        send(5'h00, 16'hFFFF, "R10 nop");
        send(5'h05, 16'h1234, "R10 unassigned scalar");
        repeat (3) @(negedge clk);
        check(acc_o == flat_acc() && opr_o == flat_opr(), "R10 scalar leaves registers",
              acc_o ^ opr_o, flat_acc() ^ flat_opr());
        check(mask_o == m_mask, "R10 scalar leaves mask", {{(N*DW-N){1'b0}}, mask_o},
              {{(N*DW-N){1'b0}}, m_mask});
        // R9 unassigned array codes complete with no effect
        send(5'h13, 16'h0, "R9 unassigned route code");
        send(5'h1F, 16'h00AA, "R9 unassigned mask code");
        send(5'h09, 16'h0003, "R9 back to back");
        drain();
        check(q.size() == 0, "R9 every instruction completed", N*DW'(q.size()), 0);

        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule